// File: doc/BRIEF.md
# I2S Master Audio Frame Transmitter

This block turns audio samples written by a host into a serial stereo stream. It is the master of the link: it drives the bit clock, the word-select line and the serial data line itself. Each channel occupies a 32-bit slot. The left slot is sent first and the right slot follows. Within a slot the most significant bit goes out first. The host supplies data through a 16-bit write port. A transmit-empty flag tells the host when the holding register can take the next half-word, and an optional interrupt follows that flag.

Three sample widths fit the 32-bit slot. A 16-bit sample needs a single write, and the block pads the low half of the slot with zeros. A 24-bit or 32-bit sample takes two writes, upper half-word first. Two alignments are offered. In the standard alignment, word-select switches one bit before the first bit of the new channel. In the MSB-justified alignment, it switches together with that first bit. If the serializer needs data while the holding register is still empty, the block sends zeros in place of the missing half-word and raises an underrun flag.

The configuration inputs are expected to stay steady while `cfg_en` is high. The bit clock runs at a fixed fraction of `clk`: each bit lasts 2*DIV_HALF clock cycles.

Top module: `i2s_frame_tx`

## Requirements
- R1: While `cfg_en` is low, `i2s_ck` rests at the level of `cfg_cpol`. While `cfg_en` is high, the logical clock (`i2s_ck` XOR `cfg_cpol`) starts low and toggles every DIV_HALF cycles of `clk`.
- R2: `i2s_sd` and `i2s_ws` change only when the logical clock falls, so a receiver samples both lines on its rising edge. The first bit appears in the cycle after `cfg_en` is first seen high.
- R3: Slots alternate left then right, starting with left. Word-select is 0 for the left channel and 1 for the right channel, and each slot is sent most significant bit first.
- R4: With `cfg_msbj`=1, word-select holds the channel value for all 32 bits of that channel's slot.
- R5: With `cfg_msbj`=0, word-select already carries the next channel's value during the last bit (bit 0) of each slot, so it switches one bit before that channel's MSB.
- R6: With `cfg_fmt`=00, one write fills a slot. The written value forms slot bits 31:16, and bits 15:0 are sent as zero.
- R7: With `cfg_fmt`=01, two writes fill a slot. The first write forms bits 31:16. Bits 15:8 of the second write form slot bits 15:8. Slot bits 7:0 are sent as zero, whatever the second write held in its low byte.
- R8: With `cfg_fmt`=10 or 11, two writes fill a slot. The first write forms bits 31:16 and the second forms bits 15:0.
- R9: `txe` is 1 after reset. It goes to 1 in the cycle after a half-word moves from the holding register to the shifter, which is before any padding or lower-half bits of that slot are sent. A write clears it in the next cycle. A write made in the same cycle as a move leaves it at 0.
- R10: `irq` equals `txe` AND `cfg_ie`.
- R11: `ch_side` gives the channel that the next written half-word belongs to (0 = left). It is 0 while the block is disabled, and it toggles once the last half-word of each slot has been taken.
- R12: If a half-word is needed while `txe` is 1, zeros are sent for that half-word and `udr` goes to 1. `udr` stays at 1 until `cfg_en` is lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| cfg_en | input | 1 | Enables the bit clock and the serializer |
| cfg_fmt | input | 2 | Sample width: 00 = 16 bits, 01 = 24 bits, 10 or 11 = 32 bits |
| cfg_msbj | input | 1 | 1 = MSB-justified alignment, 0 = standard alignment |
| cfg_cpol | input | 1 | Idle level of the bit clock |
| cfg_ie | input | 1 | Interrupt enable for transmit-empty |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW (16) | Half-word to transmit |
| txe | output | 1 | Holding register is empty |
| irq | output | 1 | Transmit-empty interrupt |
| ch_side | output | 1 | Channel of the next half-word to write (0 = left) |
| udr | output | 1 | Sticky underrun flag |
| i2s_ck | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select |
| i2s_sd | output | 1 | Serial data |

## Verification
Two functions can fall in the same cycle: a host write and a move from the holding register into the shifter. When that move finds the register empty, the collision is also an underrun. The bench provokes this by raising `cfg_en` and driving `wr_en` in the same cycle straight after reset, when `txe` is still 1. The start-of-frame move then sees an empty register while the write lands. The outcome is judged as follows: `udr` must be 1, `txe` must be 0, the left slot must be all zeros, and the written value must appear, padded, in the right slot that follows.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // Sample width selection carried on cfg_fmt.
  typedef enum logic [1:0] {
    FMT_16X32 = 2'b00,
    FMT_24X32 = 2'b01,
    FMT_32X32 = 2'b10,
    FMT_32ALT = 2'b11
  } fmt_e;

  // True when a slot is filled by two half-word writes.
  function automatic logic fmt_split(fmt_e f);
    return f != FMT_16X32;
  endfunction

endpackage

// File: rtl/i2s_tx_bitclk.sv
module i2s_tx_bitclk #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic start,
  output logic adv,
  output logic ck_lvl
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ck_q, ck_d;
  logic          run_q, run_d;
  logic          tick;

  always_comb begin
    tick  = run_q && (cnt_q == CNT_LAST);
    run_d = en;
    cnt_d = cnt_q;
    ck_d  = ck_q;
    if (!en || !run_q) begin
      cnt_d = '0;
      ck_d  = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      ck_d  = ~ck_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ck_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ck_q  <= ck_d;
      run_q <= run_d;
    end
  end

  assign start  = en && !run_q;
  assign adv    = en && tick && ck_q;
  assign ck_lvl = ck_q;

endmodule

// File: rtl/i2s_tx_slotseq.sv
module i2s_tx_slotseq #(
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic adv,
  input  logic msbj,
  output logic load_hi,
  output logic load_lo,
  output logic ws
);

  localparam int SLOT_BITS = 2 * DW;
  localparam int IW        = $clog2(SLOT_BITS);
  localparam logic [IW-1:0] IDX_LAST = IW'(SLOT_BITS - 1);
  localparam logic [IW-1:0] IDX_HALF = IW'(DW - 1);

  logic [IW-1:0] idx_q, idx_d, nxt_idx;
  logic          ch_q, ch_d, nxt_ch;
  logic          ws_q, ws_d;

  always_comb begin
    nxt_idx = (idx_q == IDX_LAST) ? '0 : idx_q + IW'(1);
    nxt_ch  = (idx_q == IDX_LAST) ? ~ch_q : ch_q;
    idx_d   = idx_q;
    ch_d    = ch_q;
    ws_d    = ws_q;
    if (!en) begin
      idx_d = '0;
      ch_d  = 1'b0;
      ws_d  = 1'b0;
    end else if (start) begin
      idx_d = '0;
      ch_d  = 1'b0;
      ws_d  = 1'b0;
    end else if (adv) begin
      idx_d = nxt_idx;
      ch_d  = nxt_ch;
      // standard alignment announces the coming channel during the last bit
      ws_d  = (!msbj && (nxt_idx == IDX_LAST)) ? ~nxt_ch : nxt_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ch_q  <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      ch_q  <= ch_d;
      ws_q  <= ws_d;
    end
  end

  assign load_hi = start || (adv && (idx_q == IDX_LAST));
  assign load_lo = adv && (idx_q == IDX_HALF);
  assign ws      = ws_q;

endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  fmt_e          fmt,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          load_hi,
  input  logic          load_lo,
  input  logic          adv,
  output logic          txe,
  output logic          udr,
  output logic          side,
  output logic          sd
);

  localparam int SW = 2 * DW;
  localparam int HB = DW / 2;

  logic [DW-1:0] hold_q, hold_d;
  logic [SW-1:0] shift_q, shift_d;
  logic          txe_q, txe_d, udr_q, udr_d, side_q, side_d;
  logic          split, take, last_take;
  logic [DW-1:0] src, src_lo;

  always_comb begin
    split     = fmt_split(fmt);
    take      = load_hi || (load_lo && split);
    last_take = split ? (load_lo && split) : load_hi;
    src       = txe_q ? '0 : hold_q;
    src_lo    = (fmt == FMT_24X32) ? {src[DW-1:HB], {HB{1'b0}}} : src;

    shift_d = shift_q;
    if (!en)                   shift_d = '0;
    else if (load_hi)          shift_d = {src, {DW{1'b0}}};
    else if (load_lo && split) shift_d = {src_lo, {DW{1'b0}}};
    else if (adv)              shift_d = shift_q << 1;

    hold_d = wr_en ? wr_data : hold_q;
    txe_d  = wr_en ? 1'b0 : (take ? 1'b1 : txe_q);
    udr_d  = en && (udr_q || (take && txe_q));
    side_d = en && (last_take ? ~side_q : side_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shift_q <= '0;
      txe_q   <= 1'b1;
      udr_q   <= 1'b0;
      side_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      shift_q <= shift_d;
      txe_q   <= txe_d;
      udr_q   <= udr_d;
      side_q  <= side_d;
    end
  end

  assign txe  = txe_q;
  assign udr  = udr_q;
  assign side = side_q;
  assign sd   = shift_q[SW-1];

endmodule

// File: rtl/i2s_frame_tx.sv
module i2s_frame_tx
  import i2s_tx_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DIV_HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_fmt,
  input  logic          cfg_msbj,
  input  logic          cfg_cpol,
  input  logic          cfg_ie,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          txe,
  output logic          irq,
  output logic          ch_side,
  output logic          udr,
  output logic          i2s_ck,
  output logic          i2s_ws,
  output logic          i2s_sd
);

  logic start, adv, ck_lvl, load_hi, load_lo;
  fmt_e fmt_c;

  assign fmt_c = fmt_e'(cfg_fmt);

  i2s_tx_bitclk #(.DIV_HALF(DIV_HALF)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .en(cfg_en),
    .start(start), .adv(adv), .ck_lvl(ck_lvl)
  );

  i2s_tx_slotseq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .start(start), .adv(adv),
    .msbj(cfg_msbj), .load_hi(load_hi), .load_lo(load_lo), .ws(i2s_ws)
  );

  i2s_tx_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .fmt(fmt_c),
    .wr_en(wr_en), .wr_data(wr_data), .load_hi(load_hi), .load_lo(load_lo),
    .adv(adv), .txe(txe), .udr(udr), .side(ch_side), .sd(i2s_sd)
  );

  assign irq    = txe & cfg_ie;
  assign i2s_ck = ck_lvl ^ cfg_cpol;

endmodule

// File: rtl/i2s_frame_tx_chk.sv
module i2s_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_cpol,
  input logic wr_en,
  input logic txe,
  input logic udr,
  input logic i2s_ck,
  input logic i2s_ws
);

  logic lvl;
  assign lvl = i2s_ck ^ cfg_cpol;

  AST_WRITE_CLEARS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !txe); // R9

  AST_TXE_RISE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txe) |-> !$past(wr_en)); // R9

  AST_CK_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (i2s_ck == cfg_cpol)); // R1

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en) && !$stable(i2s_ws)) |-> $fell(lvl)); // R2

  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (udr && cfg_en) |=> udr); // R12

endmodule

bind i2s_frame_tx i2s_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
  .wr_en(wr_en), .txe(txe), .udr(udr), .i2s_ck(i2s_ck), .i2s_ws(i2s_ws)
);

// File: tb/i2s_frame_tx_tb_top.sv
module i2s_frame_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;
  localparam int NSLOT      = 6;
  localparam int NFED       = 4;

  logic        clk = 1'b0;
  logic        rst_n, cfg_en, cfg_msbj, cfg_cpol, cfg_ie, wr_en;
  logic [1:0]  cfg_fmt;
  logic [15:0] wr_data;
  logic        txe, irq, ch_side, udr, i2s_ck, i2s_ws, i2s_sd;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [31:0] got_sd [0:NSLOT-1];
  logic [31:0] got_ws [0:NSLOT-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_frame_tx #(.DW(16), .DIV_HALF(DIV_HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_fmt(cfg_fmt),
    .cfg_msbj(cfg_msbj), .cfg_cpol(cfg_cpol), .cfg_ie(cfg_ie),
    .wr_en(wr_en), .wr_data(wr_data), .txe(txe), .irq(irq),
    .ch_side(ch_side), .udr(udr), .i2s_ck(i2s_ck), .i2s_ws(i2s_ws),
    .i2s_sd(i2s_sd)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] half_val(input int cfg, input int i);
    return 16'(32'h8E5A + cfg * 32'h0F31 + i * 32'h1357);
  endfunction

  function automatic logic [31:0] slot_exp(input int fmt, input int cfg, input int s);
    logic [15:0] a, b;
    if (s >= NFED) return 32'h0;
    if (fmt == 0) return {half_val(cfg, s), 16'h0};
    a = half_val(cfg, 2 * s);
    b = half_val(cfg, 2 * s + 1);
    if (fmt == 1) return {a, b[15:8], 8'h00};
    return {a, b};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cfg_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] d);
    while (!txe) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic writer(input int cfg, input int nh);
    for (int i = 1; i < nh; i++) host_write(half_val(cfg, i));
  endtask

  // Collects bits on rising edges of the logical clock.
  task automatic receiver(input logic cpol, input int total, input bit mid_chk);
    logic prev = 1'b0;
    logic lvl;
    int n = 0;
    while (n < total) begin
      @(negedge clk);
      lvl = i2s_ck ^ cpol;
      if (lvl && !prev) begin
        got_sd[n / 32][31 - (n % 32)] = i2s_sd;
        got_ws[n / 32][31 - (n % 32)] = i2s_ws;
        if (mid_chk && n == NFED * 32 - 1)
          chk({31'b0, udr}, 32'h0, "R12 no underrun while fed");
        n++;
      end
      prev = lvl;
    end
  endtask

  task automatic run_cfg(input int fmt, input logic msbj, input logic cpol);
    int cfg = fmt * 4 + int'(msbj) * 2 + int'(cpol);
    logic ie = msbj ^ cpol;
    bit split = (fmt != 0);
    int nh = split ? 2 * NFED : NFED;
    logic ch;
    string tag_d;
    do_reset();
    cfg_fmt = 2'(fmt); cfg_msbj = msbj; cfg_cpol = cpol; cfg_ie = ie;
    @(negedge clk);
    chk({31'b0, i2s_ck}, {31'b0, cpol}, "R1 idle clock level");
    chk({31'b0, txe}, 32'h1, "R9 txe after reset");
    chk({31'b0, ch_side}, 32'h0, "R11 side after reset");
    chk({31'b0, irq}, {31'b0, ie}, "R10 irq follows txe");
    host_write(half_val(cfg, 0));
    chk({31'b0, txe}, 32'h0, "R9 write clears txe");
    chk({31'b0, irq}, 32'h0, "R10 irq low when full");
    cfg_en = 1'b1;
    @(negedge clk);
    chk({31'b0, txe}, 32'h1, "R9 txe set once upper half taken");
    chk({31'b0, ch_side}, {31'b0, !split}, "R11 side after first take");
    chk({31'b0, irq}, {31'b0, ie}, "R10 irq after take");
    fork
      writer(cfg, nh);
      receiver(cpol, NSLOT * 32, 1'b1);
    join
    for (int s = 0; s < NSLOT; s++) begin
      ch = s[0];
      tag_d = (s >= NFED) ? "R12 zero slot" : (fmt == 0) ? "R6 slot data" :
              (fmt == 1) ? "R7 slot data" : "R8 slot data";
      chk(got_sd[s], slot_exp(fmt, cfg, s), $sformatf("%s cfg %0d slot %0d", tag_d, cfg, s));
      chk(got_ws[s], msbj ? {32{ch}} : {{31{ch}}, ~ch},
          $sformatf("%s cfg %0d slot %0d", msbj ? "R3 R4 ws" : "R3 R5 ws", cfg, s));
    end
    chk({31'b0, udr}, 32'h1, "R12 underrun after feed stops");
    cfg_en = 1'b0;
    repeat (2) @(negedge clk);
    chk({31'b0, i2s_ck}, {31'b0, cpol}, "R1 clock idles after disable");
    chk({31'b0, udr}, 32'h0, "R12 underrun cleared by disable");
    chk({31'b0, ch_side}, 32'h0, "R11 side cleared by disable");
  endtask

  // Write lands in the same cycle as the start-of-frame move from an empty register.
  task automatic collide();
    do_reset();
    cfg_fmt = 2'b00; cfg_msbj = 1'b1; cfg_cpol = 1'b0; cfg_ie = 1'b1;
    @(negedge clk);
    cfg_en = 1'b1; wr_en = 1'b1; wr_data = 16'hC3A5;
    @(negedge clk);
    wr_en = 1'b0;
    chk({31'b0, udr}, 32'h1, "R12 collision underrun");
    chk({31'b0, txe}, 32'h0, "R9 colliding write keeps txe low");
    chk({31'b0, ch_side}, 32'h1, "R11 side after colliding take");
    receiver(1'b0, 64, 1'b0);
    chk(got_sd[0], 32'h0, "R12 collision left slot zero");
    chk(got_sd[1], 32'hC3A5_0000, "R6 collision right slot");
    cfg_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int f = 0; f < 3; f++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 2; p++)
          run_cfg(f, m[0], p[0]);
    collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1-chain: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule